// File: doc/BRIEF.md
# Memory-type-aware cache controller

This block is a small direct-mapped data cache controller. It sits between a CPU-side request port and a memory port that moves one word at a time. Each request carries a two-bit memory-type tag. The tag decides, for that access alone, whether the block allocates a line, whether a write reaches memory, and whether a matching line is kept, updated or dropped. The block stores a tag, a valid bit and a dirty bit for each set. On a miss it fetches a whole line, and before it reuses a set it writes back a modified victim.

Two maintenance operations share the same state machine. A flush walks every set and cleans each dirty line. A snoop-invalidate removes the line that holds a given address, and writes that line back first if it is dirty. One request is handled at a time. When a flush, a snoop and a request wait in the same cycle, the flush goes first, then the snoop, then the request.

State machine:
- States: IDLE, LOOKUP, WRITEBACK, FILL, MEMWRITE, RESPOND.
- IDLE→LOOKUP when a flush, a snoop or a request is taken.
- LOOKUP→RESPOND on a read hit, on a write-back write hit, at a snoop with nothing to clean, or at the last clean set of a flush.
- LOOKUP→LOOKUP moves to the next set of a flush walk when the current set is clean.
- LOOKUP→WRITEBACK when a dirty line must leave the set.
- LOOKUP→FILL on a cacheable miss that allocates, and for an uncacheable read.
- LOOKUP→MEMWRITE for uncacheable, write-through and write-protected writes.
- WRITEBACK→FILL when a miss is waiting for its fill.
- WRITEBACK→MEMWRITE for a write-protected write.
- WRITEBACK→LOOKUP to continue a flush walk.
- WRITEBACK→RESPOND at the end of a snoop or of the flush walk.
- FILL→LOOKUP after a cacheable line arrives; the request is then looked up again and hits.
- FILL→RESPOND after the single word of an uncacheable read.
- MEMWRITE→RESPOND after the memory accepts the word.
- RESPOND→IDLE always.

Top module: `mtc_top`

## Requirements
- R1: Type code 00 is uncacheable. An uncacheable read makes exactly one memory read at the request address and returns that word. An uncacheable write makes exactly one memory write. Neither one changes any cached line, so a later cached read of the same address still returns the old cached word.
- R2: Type code 11 is write-back. A write-back read hit returns the cached word with no memory traffic. A write-back read miss fetches the whole line: LINE_WORDS reads, in ascending word order. Address layout: word offset in bits [1:0], set in [4:2], tag in [9:5].
- R3: A write-back write miss first fetches the line. It then updates the word only in the cache and marks the line modified. No memory write is issued, and a later read returns the new value.
- R4: A miss that needs a fill, landing on a set that holds a valid modified line, first writes all LINE_WORDS words of that victim to memory in ascending order. Only then does it fetch the new line.
- R5: Type code 01 is write-through. Every write-through write makes exactly one memory write. On a miss it allocates nothing, so a later read misses. On a hit it updates the cached word in place.
- R6: Type code 10 is write-protected. Reads behave as write-back reads. A write goes to memory as one word and invalidates the matching line without updating it. If that line is modified, it is written back first.
- R7: A flush writes back every valid modified line, leaves those lines valid and clean, and ends with a one-cycle flush_done pulse. A second flush right after the first makes no memory write.
- R8: A snoop-invalidate at an address writes back the matching line if it is modified, then invalidates it, and ends with a one-cycle inv_done pulse. A snoop with no matching line causes no memory traffic.
- R9: req_ready is high only while the block is idle. Only one request is outstanding at a time. Each request ends with a one-cycle rsp_done pulse, and for reads rsp_rdata holds the data during that pulse.
- R10: When requests arrive in the same cycle, flush_req wins over inv_req, and inv_req wins over req_valid. req_ready stays low while flush_req or inv_req is high.
- R11: Once mem_req is raised, mem_req, mem_addr, mem_write and mem_wdata hold steady until mem_ack is seen.
- R12: After reset the cache is empty and idle. req_ready is high, no memory request is active, and the first access to any address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Request taken in this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mtype | input | 2 | Memory type: 00 UC, 01 WT, 10 WP, 11 WB |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done |
| flush_req | input | 1 | Flush request, held until flush_done |
| flush_done | output | 1 | One-cycle flush completion pulse |
| inv_req | input | 1 | Snoop-invalidate request, held until inv_done |
| inv_addr | input | ADDR_W | Address to invalidate |
| inv_done | output | 1 | One-cycle invalidate completion pulse |
| mem_req | output | 1 | Memory word access request |
| mem_write | output | 1 | 1 = memory write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory accepted the word; read data valid |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
A flush, a snoop-invalidate and a CPU read can all arrive in the same idle cycle, and the three compete for the one state machine. The bench raises flush_req, inv_req and req_valid together, at a time when the snooped line is modified. It then checks three things: the three done pulses arrive in the order flush, snoop, request; req_ready stays low while either maintenance request is high; and the memory traffic equals the model's sequence. In that sequence the flush cleans the line, the snoop drops it with no write, and the read fetches the line again.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
    typedef enum logic [1:0] {
        MT_UC = 2'b00,
        MT_WT = 2'b01,
        MT_WP = 2'b10,
        MT_WB = 2'b11
    } mtype_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOOKUP,
        S_WRITEBACK,
        S_FILL,
        S_MEMWRITE,
        S_RESPOND
    } state_e;

    typedef enum logic [1:0] {
        OP_REQ,
        OP_FLUSH,
        OP_SNOOP
    } op_e;
endpackage

// File: rtl/mtc_store.sv
module mtc_store #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 5,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [OFF_W-1:0]  word,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] dat_wdata,
    input  logic              meta_we,
    input  logic              meta_valid,
    input  logic              meta_dirty,
    input  logic [TAG_W-1:0]  meta_tag
);
    localparam int NSETS  = 1 << IDX_W;
    localparam int NWORDS = NSETS << OFF_W;

    logic [DATA_W-1:0] data_q [NWORDS];
    logic [TAG_W-1:0]  tag_q  [NSETS];
    logic [NSETS-1:0]  valid_q;
    logic [NSETS-1:0]  dirty_q;

    always_ff @(posedge clk) begin
        if (dat_we) data_q[{idx, word}] <= dat_wdata;
        if (meta_we) tag_q[idx] <= meta_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (meta_we) begin
            valid_q[idx] <= meta_valid;
            dirty_q[idx] <= meta_dirty;
        end
    end

    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_tag   = tag_q[idx];
    assign rd_data  = data_q[{idx, word}];
endmodule

// File: rtl/mtc_top.sv
module mtc_top
    import mtc_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int SETS       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_mtype,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              flush_req,
    output logic              flush_done,
    input  logic              inv_req,
    input  logic [ADDR_W-1:0] inv_addr,
    output logic              inv_done,
    output logic              mem_req,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int OFF_W = $clog2(LINE_WORDS);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    state_e state_q, state_d;
    op_e    op_q;
    mtype_e r_mtype;
    logic [ADDR_W-1:0] r_addr;
    logic              r_write;
    logic [DATA_W-1:0] r_wdata, r_rdata;
    logic [OFF_W-1:0]  cnt;

    logic [TAG_W-1:0]  rtag, rd_tag, meta_tag;
    logic [IDX_W-1:0]  idx;
    logic [OFF_W-1:0]  off, word_sel;
    logic              rd_valid, rd_dirty, hit, victim_dirty, is_uc, wp_write;
    logic              last_set, mem_beat, beat_last;
    logic [DATA_W-1:0] rd_data, dat_wdata;
    logic              dat_we, meta_we, meta_valid, meta_dirty;

    assign rtag         = r_addr[ADDR_W-1 -: TAG_W];
    assign idx          = r_addr[OFF_W +: IDX_W];
    assign off          = r_addr[OFF_W-1:0];
    assign hit          = rd_valid && (rd_tag == rtag);
    assign victim_dirty = rd_valid && rd_dirty;
    assign is_uc        = (r_mtype == MT_UC);
    assign wp_write     = r_write && (r_mtype == MT_WP);
    assign last_set     = &idx;
    assign mem_beat     = mem_req && mem_ack;
    assign beat_last    = mem_beat && (&cnt);
    assign word_sel     = (state_q == S_WRITEBACK || state_q == S_FILL) ? cnt : off;
    assign rsp_rdata    = r_rdata;

    mtc_store #(.DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_store (
        .clk(clk), .rst_n(rst_n), .idx(idx), .word(word_sel),
        .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag), .rd_data(rd_data),
        .dat_we(dat_we), .dat_wdata(dat_wdata),
        .meta_we(meta_we), .meta_valid(meta_valid), .meta_dirty(meta_dirty), .meta_tag(meta_tag)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (flush_req || inv_req || req_valid) state_d = S_LOOKUP;
            S_LOOKUP: begin
                unique case (op_q)
                    OP_FLUSH: begin
                        if (victim_dirty)  state_d = S_WRITEBACK;
                        else if (last_set) state_d = S_RESPOND;
                    end
                    OP_SNOOP: state_d = (hit && rd_dirty) ? S_WRITEBACK : S_RESPOND;
                    default: begin
                        if (is_uc)         state_d = r_write ? S_MEMWRITE : S_FILL;
                        else if (!r_write) state_d = hit ? S_RESPOND
                                                   : (victim_dirty ? S_WRITEBACK : S_FILL);
                        else begin
                            unique case (r_mtype)
                                MT_WT:   state_d = S_MEMWRITE;
                                MT_WP:   state_d = (hit && rd_dirty) ? S_WRITEBACK : S_MEMWRITE;
                                default: state_d = hit ? S_RESPOND
                                                 : (victim_dirty ? S_WRITEBACK : S_FILL);
                            endcase
                        end
                    end
                endcase
            end
            S_WRITEBACK: if (beat_last) begin
                unique case (op_q)
                    OP_FLUSH: state_d = last_set ? S_RESPOND : S_LOOKUP;
                    OP_SNOOP: state_d = S_RESPOND;
                    default:  state_d = wp_write ? S_MEMWRITE : S_FILL;
                endcase
            end
            S_FILL: begin
                if (is_uc) begin
                    if (mem_beat) state_d = S_RESPOND;
                end else if (beat_last) begin
                    state_d = S_LOOKUP;
                end
            end
            S_MEMWRITE: if (mem_beat) state_d = S_RESPOND;
            S_RESPOND:  state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // outputs and array controls
    always_comb begin
        req_ready  = 1'b0;
        rsp_done   = 1'b0;
        flush_done = 1'b0;
        inv_done   = 1'b0;
        mem_req    = 1'b0;
        mem_write  = 1'b0;
        mem_addr   = r_addr;
        mem_wdata  = r_wdata;
        dat_we     = 1'b0;
        dat_wdata  = r_wdata;
        meta_we    = 1'b0;
        meta_valid = rd_valid;
        meta_dirty = rd_dirty;
        meta_tag   = rd_tag;
        unique case (state_q)
            S_IDLE: req_ready = !flush_req && !inv_req;
            S_LOOKUP: begin
                if (op_q == OP_SNOOP && hit && !rd_dirty) begin
                    meta_we    = 1'b1;
                    meta_valid = 1'b0;
                end else if (op_q == OP_REQ && !is_uc && r_write && hit) begin
                    unique case (r_mtype)
                        MT_WT: dat_we = 1'b1;
                        MT_WP: if (!rd_dirty) begin
                            meta_we    = 1'b1;
                            meta_valid = 1'b0;
                        end
                        default: begin
                            dat_we     = 1'b1;
                            meta_we    = 1'b1;
                            meta_dirty = 1'b1;
                        end
                    endcase
                end
            end
            S_WRITEBACK: begin
                mem_req   = 1'b1;
                mem_write = 1'b1;
                mem_addr  = {rd_tag, idx, cnt};
                mem_wdata = rd_data;
                if (beat_last) begin
                    meta_we    = 1'b1;
                    meta_dirty = 1'b0;
                    if (op_q == OP_SNOOP || (op_q == OP_REQ && wp_write)) meta_valid = 1'b0;
                end
            end
            S_FILL: begin
                mem_req = 1'b1;
                if (!is_uc) begin
                    mem_addr  = {rtag, idx, cnt};
                    dat_we    = mem_beat;
                    dat_wdata = mem_rdata;
                    if (beat_last) begin
                        meta_we    = 1'b1;
                        meta_valid = 1'b1;
                        meta_dirty = 1'b0;
                        meta_tag   = rtag;
                    end
                end
            end
            S_MEMWRITE: begin
                mem_req   = 1'b1;
                mem_write = 1'b1;
            end
            S_RESPOND: begin
                rsp_done   = (op_q == OP_REQ);
                flush_done = (op_q == OP_FLUSH);
                inv_done   = (op_q == OP_SNOOP);
            end
            default: ;
        endcase
    end

    // request capture and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_REQ;
            r_mtype <= MT_UC;
            r_addr  <= '0;
            r_write <= 1'b0;
            r_wdata <= '0;
            r_rdata <= '0;
            cnt     <= '0;
        end else begin
            if (state_q == S_IDLE) begin
                if (flush_req) begin
                    op_q   <= OP_FLUSH;
                    r_addr <= '0;
                end else if (inv_req) begin
                    op_q   <= OP_SNOOP;
                    r_addr <= inv_addr;
                end else if (req_valid) begin
                    op_q    <= OP_REQ;
                    r_addr  <= req_addr;
                    r_write <= req_write;
                    r_wdata <= req_wdata;
                    r_mtype <= mtype_e'(req_mtype);
                end
            end
            if (state_q == S_LOOKUP) r_rdata <= rd_data;
            if (state_q == S_FILL && is_uc && mem_beat) r_rdata <= mem_rdata;
            if ((state_q == S_WRITEBACK || (state_q == S_FILL && !is_uc)) && mem_beat)
                cnt <= cnt + 1'b1;
            if (op_q == OP_FLUSH && !last_set &&
                ((state_q == S_LOOKUP && !victim_dirty) || (state_q == S_WRITEBACK && beat_last)))
                r_addr[OFF_W +: IDX_W] <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/mtc_checker.sv
module mtc_checker #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              flush_req,
    input logic              inv_req,
    input logic              rsp_done,
    input logic              flush_done,
    input logic              inv_done,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata
);
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !req_ready);

    a_r7_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !flush_done);

    a_r8_inv_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        inv_done |=> !inv_done);

    a_r10_flush_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> !req_ready);

    a_r10_snoop_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
        inv_req |-> !req_ready);

    a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_write)
                                   && $stable(mem_wdata)));
endmodule

bind mtc_top mtc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .flush_req(flush_req),
    .inv_req(inv_req), .rsp_done(rsp_done), .flush_done(flush_done), .inv_done(inv_done),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
);

// File: tb/sim_mtc_top.sv
module sim_mtc_top;
    localparam int AW = 10, DW = 32, LW = 4, NS = 8, MEMN = 1 << AW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, flush_req = 0, inv_req = 0;
    logic [1:0] req_mtype = 0;
    logic [AW-1:0] req_addr = 0, inv_addr = 0;
    logic [DW-1:0] req_wdata = 0;
    logic req_ready, rsp_done, flush_done, inv_done, mem_req, mem_write;
    logic [DW-1:0] rsp_rdata, mem_wdata;
    logic [AW-1:0] mem_addr;
    logic mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    mtc_top #(.ADDR_W(AW), .DATA_W(DW), .LINE_WORDS(LW), .SETS(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_mtype(req_mtype), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .flush_req(flush_req), .flush_done(flush_done), .inv_req(inv_req),
        .inv_addr(inv_addr), .inv_done(inv_done), .mem_req(mem_req),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_vec = 0, n_bad = 0;
    bit busy = 0;

    // memory behind the block, with traffic logs
    logic [DW-1:0] mem [MEMN];
    int unsigned       rd_log[$];
    longint unsigned   wr_log[$];
    int unsigned       exp_rd[$];
    longint unsigned   exp_wr[$];

    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                if (mem_write) begin
                    mem[mem_addr] <= mem_wdata;
                    wr_log.push_back((64'(mem_addr) << 32) | 64'(mem_wdata));
                end else begin
                    mem_rdata <= mem[mem_addr];
                    rd_log.push_back(32'(mem_addr));
                end
            end
        end
    end

    // behavioural reference model
    logic [DW-1:0] m_mem [MEMN];
    bit            cv [NS];
    bit            cd [NS];
    int            ct [NS];
    logic [DW-1:0] cdat [NS][LW];

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic m_evict(int s);
        if (cv[s] && cd[s]) begin
            for (int w = 0; w < LW; w++) begin
                int a;
                a = (ct[s] * NS + s) * LW + w;
                exp_wr.push_back((64'(a) << 32) | 64'(cdat[s][w]));
                m_mem[a] = cdat[s][w];
            end
            cd[s] = 0;
        end
    endtask

    task automatic m_fill(int s, int t);
        for (int w = 0; w < LW; w++) begin
            int a;
            a = (t * NS + s) * LW + w;
            exp_rd.push_back(a);
            cdat[s][w] = m_mem[a];
        end
        cv[s] = 1; ct[s] = t; cd[s] = 0;
    endtask

    task automatic m_access(bit wr, int a, logic [DW-1:0] d, logic [1:0] mt,
                            output logic [DW-1:0] rd);
        int s, t, w;
        bit hit;
        s = (a / LW) % NS; t = a / (LW * NS); w = a % LW;
        hit = cv[s] && (ct[s] == t);
        rd = '0;
        if (mt == 2'b00) begin
            if (wr) begin exp_wr.push_back((64'(a) << 32) | 64'(d)); m_mem[a] = d; end
            else begin exp_rd.push_back(a); rd = m_mem[a]; end
        end else if (!wr) begin
            if (!hit) begin m_evict(s); m_fill(s, t); end
            rd = cdat[s][w];
        end else if (mt == 2'b01) begin
            exp_wr.push_back((64'(a) << 32) | 64'(d)); m_mem[a] = d;
            if (hit) cdat[s][w] = d;
        end else if (mt == 2'b10) begin
            if (hit) begin m_evict(s); cv[s] = 0; end
            exp_wr.push_back((64'(a) << 32) | 64'(d)); m_mem[a] = d;
        end else begin
            if (!hit) begin m_evict(s); m_fill(s, t); end
            cdat[s][w] = d; cd[s] = 1;
        end
    endtask

    task automatic m_snoop(int a);
        int s;
        s = (a / LW) % NS;
        if (cv[s] && ct[s] == a / (LW * NS)) begin m_evict(s); cv[s] = 0; end
    endtask

    task automatic m_flush();
        for (int s = 0; s < NS; s++) m_evict(s);
    endtask

    task automatic start_txn();
        rd_log.delete(); wr_log.delete(); exp_rd.delete(); exp_wr.delete();
    endtask

    task automatic finish_txn(string req);
        int bad, first;
        check(rd_log.size() == exp_rd.size(), req, "memory read count", rd_log.size(), exp_rd.size());
        for (int i = 0; i < rd_log.size() && i < exp_rd.size(); i++)
            check(rd_log[i] == exp_rd[i], req, "memory read address", rd_log[i], exp_rd[i]);
        check(wr_log.size() == exp_wr.size(), req, "memory write count", wr_log.size(), exp_wr.size());
        for (int i = 0; i < wr_log.size() && i < exp_wr.size(); i++)
            check(wr_log[i] == exp_wr[i], req, "memory write addr/data", wr_log[i], exp_wr[i]);
        bad = 0; first = 0;
        for (int i = 0; i < MEMN; i++)
            if (mem[i] !== m_mem[i]) begin if (bad == 0) first = i; bad++; end
        check(bad == 0, req, "memory image word", mem[first], m_mem[first]);
    endtask

    task automatic do_req(bit wr, int a, logic [DW-1:0] d, logic [1:0] mt, string req);
        logic [DW-1:0] exp;
        start_txn();
        m_access(wr, a, d, mt, exp);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = d; req_mtype = mt;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        busy = 1;
        @(negedge clk);
        req_valid = 0;
        while (!rsp_done) @(negedge clk);
        if (!wr) check(rsp_rdata == exp, req, "read data", rsp_rdata, exp);
        busy = 0;
        finish_txn(req);
        @(negedge clk);
        check(!rsp_done && req_ready, "R9", "done pulse width / ready after", {rsp_done, req_ready}, 2'b01);
    endtask

    task automatic do_flush(string req);
        start_txn();
        m_flush();
        @(negedge clk);
        flush_req = 1;
        while (!flush_done) @(negedge clk);
        flush_req = 0;
        finish_txn(req);
        @(negedge clk);
        check(!flush_done, "R7", "flush_done pulse width", flush_done, 0);
    endtask

    task automatic do_snoop(int a, string req);
        start_txn();
        m_snoop(a);
        @(negedge clk);
        inv_req = 1; inv_addr = AW'(a);
        while (!inv_done) @(negedge clk);
        inv_req = 0;
        finish_txn(req);
        @(negedge clk);
        check(!inv_done, "R8", "inv_done pulse width", inv_done, 0);
    endtask

    // per-clock comparison of the port protocol
    logic          p_req = 0, p_ack = 0, p_wr = 0;
    logic [AW-1:0] p_addr = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) check(!req_ready, "R9", "req_ready while busy", req_ready, 0);
            if (p_req && !p_ack)
                check(mem_req && mem_addr == p_addr && mem_write == p_wr, "R11",
                      "memory request hold", {mem_req, mem_write, mem_addr}, {1'b1, p_wr, p_addr});
        end
        p_req = mem_req; p_ack = mem_ack; p_addr = mem_addr; p_wr = mem_write;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL R9 watchdog: actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] dummy;
        for (int i = 0; i < MEMN; i++) begin
            mem[i] = 32'hA500_0000 + i;
            m_mem[i] = 32'hA500_0000 + i;
        end
        for (int s = 0; s < NS; s++) begin cv[s] = 0; cd[s] = 0; ct[s] = 0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12: reset state
        check(req_ready && !mem_req && !rsp_done && !flush_done && !inv_done, "R12",
              "idle after reset", {req_ready, mem_req, rsp_done, flush_done, inv_done}, 5'b10000);

        // R2 / R12: first access misses and fills; then a hit
        do_req(0, 'h010, 0, 2'b11, "R12");
        do_req(0, 'h013, 0, 2'b11, "R2");
        // R3: write-back write miss allocates, stays in cache
        do_req(1, 'h041, 32'hDEAD_0041, 2'b11, "R3");
        do_req(0, 'h041, 0, 2'b11, "R3");
        // R4: dirty victim written back before fill
        do_req(0, 'h001, 0, 2'b11, "R4");
        // R1: uncacheable bypass
        do_req(0, 'h011, 0, 2'b00, "R1");
        do_req(1, 'h012, 32'h0C0C_0012, 2'b00, "R1");
        do_req(0, 'h012, 0, 2'b11, "R1");
        // R5: write-through
        do_req(1, 'h0A0, 32'h5757_00A0, 2'b01, "R5");
        do_req(0, 'h0A0, 0, 2'b01, "R5");
        do_req(1, 'h0A1, 32'h5757_00A1, 2'b01, "R5");
        do_req(0, 'h0A1, 0, 2'b01, "R5");
        // R6: write-protected
        do_req(0, 'h0C8, 0, 2'b10, "R6");
        do_req(0, 'h0CA, 0, 2'b10, "R6");
        do_req(1, 'h0C9, 32'h6060_00C9, 2'b10, "R6");
        do_req(0, 'h0C9, 0, 2'b10, "R6");
        do_req(1, 'h0CA, 32'h6161_00CA, 2'b11, "R6");
        do_req(1, 'h0CB, 32'h6262_00CB, 2'b10, "R6");
        do_req(0, 'h0CA, 0, 2'b10, "R6");
        // R7: flush
        do_req(1, 'h108, 32'h7070_0108, 2'b11, "R7");
        do_req(1, 'h11C, 32'h7171_011C, 2'b11, "R7");
        do_flush("R7");
        do_flush("R7");
        do_req(0, 'h11C, 0, 2'b11, "R7");
        // R8: snoop-invalidate
        do_req(1, 'h150, 32'h8080_0150, 2'b11, "R8");
        do_snoop('h150, "R8");
        do_req(0, 'h150, 0, 2'b11, "R8");
        do_snoop('h3F0, "R8");

        // R10: flush, snoop and request in the same cycle
        begin
            int tf, ti, tr, cyc;
            bit drop;
            logic [DW-1:0] exp;
            do_req(1, 'h1E4, 32'hA1A1_01E4, 2'b11, "R10");
            start_txn();
            m_flush(); m_snoop('h1E4); m_access(0, 'h1E4, 0, 2'b11, exp);
            tf = -1; ti = -1; tr = -1; cyc = 0; drop = 0;
            @(negedge clk);
            flush_req = 1; inv_req = 1; inv_addr = 'h1E4;
            req_valid = 1; req_write = 0; req_addr = 'h1E4; req_mtype = 2'b11;
            while (tr < 0) begin
                @(negedge clk);
                cyc++;
                if (drop) req_valid = 0;
                if (flush_req || inv_req)
                    check(!req_ready, "R10", "ready while maintenance pending", req_ready, 0);
                if (flush_done) begin tf = cyc; flush_req = 0; end
                if (inv_done) begin ti = cyc; inv_req = 0; end
                if (rsp_done) begin
                    tr = cyc;
                    check(rsp_rdata == exp, "R10", "read data after flush+snoop", rsp_rdata, exp);
                end
                if (req_valid && req_ready) drop = 1;
            end
            check(tf > 0 && ti > tf && tr > ti, "R10", "completion order f<i<r",
                  (longint'(tf) << 32) | longint'(ti), tr);
            finish_txn("R10");
        end

        // mixed traffic against the model
        for (int k = 0; k < 300; k++) begin
            int kind, a;
            logic [1:0] mt;
            kind = $urandom_range(0, 19);
            a = $urandom_range(0, 255);
            mt = 2'($urandom_range(0, 3));
            if (kind == 0) do_flush("R7");
            else if (kind == 1) do_snoop(a, "R8");
            else do_req(bit'($urandom_range(0, 1)), a, $urandom,
                        mt, mt == 2'b00 ? "R1" : mt == 2'b01 ? "R5" : mt == 2'b10 ? "R6" : "R4");
        end
        dummy = '0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule